// File: doc/BRIEF.md
# Accumulator ALU with Flag Generation

This block is the purely combinational arithmetic and logic stage of a small accumulator-based controller. Each cycle the surrounding datapath presents the accumulator value, a second operand (or the B register for multiply and divide), the current carry and auxiliary-carry flags, and a 5-bit operation code. The block returns the new accumulator byte, a second byte for the B register, and new carry, auxiliary-carry and overflow values. Each output that may change has its own write-enable. When an enable is low, the caller keeps its stored value.

The flag rules follow the controller's conventions. Subtraction always consumes the borrow. Increment and decrement never touch the flags. Division reports a zero divisor on overflow. Decimal adjust works from both carry flags. Register storage, operand fetch, decode and the parity flag belong to the surrounding logic.

Top module: `acc_alu`

## Requirements
- R1: ADD (code 0) gives res = (acc + opnd) mod 256. ADDC (code 1) also adds cy_i. Both write carry, set to 1 when the unsigned sum exceeds 0xFF.
- R2: For ADD and ADDC, auxiliary carry is written and equals the carry out of bit 3 (low nibbles plus carry-in exceed 15).
- R3: For ADD and ADDC, overflow is written and is set when exactly one of the carries out of bit 6 and bit 7 occurs, i.e. the signed sum leaves -128..127. 0x3F + 0xD3 gives carry=1, aux=1, overflow=0.
- R4: SUBB (code 2) gives res = (acc - opnd - cy_i) mod 256 and writes all three flags:
  - carry = borrow out of bit 7;
  - aux = borrow out of bit 3;
  - overflow = the signed difference leaves -128..127.
- R5: INC (code 3) and DEC (code 4) give acc+1 and acc-1, wrapping, and raise no flag write-enable.
- R6: MUL (code 5) puts the low product byte on res_o and the high byte on res2_o with res2_we_o=1. It writes carry=0 and writes overflow=1 exactly when the product exceeds 0xFF. 0xFF*0xFF gives 0xFE01.
- R7: DIV (code 6) with a non-zero opnd puts the quotient on res_o and the remainder on res2_o with res2_we_o=1. It writes carry=0 and overflow=0.
- R8: DIV with opnd=0 returns res_o=acc_i and res2_o=opnd_i, writes carry=0 and writes overflow=1.
- R9: DA (code 7) adjusts acc in two steps and writes carry, which it can only set, never clear:
  - it adds 0x06 if the low nibble exceeds 9 or ac_i=1;
  - it then adds 0x60 if the high nibble exceeds 9, cy_i=1 or the first step passed 0xFF, and in that case writes carry=1.
  For example, 0x4C with no flags gives 0x52.
- R10: AND (8), OR (9) and XOR (10) with opnd, complement (11) and clear (12) produce the bitwise result and raise no flag write-enable.
- R11: Rotate and swap produce the shifted result:
  - RL (13) and RR (15) rotate the 8 bits and raise no flag enable;
  - RLC (14) and RRC (16) rotate through carry and write carry with the bit shifted out;
  - SWAP (17) exchanges the nibbles with no flag enable.
- R12: Codes 18 to 31 return res_o=acc_i with every write-enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand / B register |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| res_o | output | 8 | New accumulator value |
| res2_o | output | 8 | Second result byte (B register) |
| res2_we_o | output | 1 | Write-enable for res2_o |
| cy_o | output | 1 | New carry flag |
| cy_we_o | output | 1 | Write-enable for carry |
| ac_o | output | 1 | New auxiliary-carry flag |
| ac_we_o | output | 1 | Write-enable for auxiliary carry |
| ov_o | output | 1 | New overflow flag |
| ov_we_o | output | 1 | Write-enable for overflow |

## Verification
The block has a single fixed configuration: 8-bit operands and a 5-bit code. The bench therefore reaches every operand pair for the two-operand operations, including both carry-in values for add and subtract. It covers every accumulator value with each flag combination for decimal adjust, rotates and the unused codes. Every zero-divisor case and the full-scale product corner fall out of these sweeps rather than needing hand-picked vectors.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic [4:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic       cy_i,
  input  logic       ac_i,
  output logic [7:0] res_o,
  output logic [7:0] res2_o,
  output logic       res2_we_o,
  output logic       cy_o,
  output logic       cy_we_o,
  output logic       ac_o,
  output logic       ac_we_o,
  output logic       ov_o,
  output logic       ov_we_o
);

  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_ADDC = 5'd1;
  localparam logic [4:0] OP_SUBB = 5'd2;
  localparam logic [4:0] OP_INC  = 5'd3;
  localparam logic [4:0] OP_DEC  = 5'd4;
  localparam logic [4:0] OP_MUL  = 5'd5;
  localparam logic [4:0] OP_DIV  = 5'd6;
  localparam logic [4:0] OP_DA   = 5'd7;
  localparam logic [4:0] OP_AND  = 5'd8;
  localparam logic [4:0] OP_OR   = 5'd9;
  localparam logic [4:0] OP_XOR  = 5'd10;
  localparam logic [4:0] OP_CPL  = 5'd11;
  localparam logic [4:0] OP_CLR  = 5'd12;
  localparam logic [4:0] OP_RL   = 5'd13;
  localparam logic [4:0] OP_RLC  = 5'd14;
  localparam logic [4:0] OP_RR   = 5'd15;
  localparam logic [4:0] OP_RRC  = 5'd16;
  localparam logic [4:0] OP_SWAP = 5'd17;

  logic        cin;
  logic [8:0]  add9, sub9, da_t;
  logic [4:0]  add_lo;
  logic        sub_lo_brw;
  logic [15:0] prod;
  logic [7:0]  dvsr, quot, rmdr, da_res;
  logic        da_lo_fix, da_hi_fix;

  assign cin        = (op_i == OP_ADDC || op_i == OP_SUBB) ? cy_i : 1'b0;
  assign add9       = {1'b0, acc_i} + {1'b0, opnd_i} + {8'd0, cin};
  assign add_lo     = {1'b0, acc_i[3:0]} + {1'b0, opnd_i[3:0]} + {4'd0, cin};
  assign sub9       = {1'b0, acc_i} - {1'b0, opnd_i} - {8'd0, cin};
  assign sub_lo_brw = {1'b0, acc_i[3:0]} < ({1'b0, opnd_i[3:0]} + {4'd0, cin});
  assign prod       = {8'd0, acc_i} * {8'd0, opnd_i};
  assign dvsr       = (opnd_i == 8'd0) ? 8'd1 : opnd_i;
  assign quot       = acc_i / dvsr;
  assign rmdr       = acc_i % dvsr;
  assign da_lo_fix  = (acc_i[3:0] > 4'd9) || ac_i;
  assign da_t       = {1'b0, acc_i} + (da_lo_fix ? 9'd6 : 9'd0);
  assign da_hi_fix  = (da_t[7:4] > 4'd9) || cy_i || da_t[8];
  assign da_res     = da_t[7:0] + (da_hi_fix ? 8'h60 : 8'h00);

  always_comb begin
    res_o     = acc_i;
    res2_o    = opnd_i;
    res2_we_o = 1'b0;
    cy_o      = cy_i;
    cy_we_o   = 1'b0;
    ac_o      = ac_i;
    ac_we_o   = 1'b0;
    ov_o      = 1'b0;
    ov_we_o   = 1'b0;
    case (op_i)
      OP_ADD, OP_ADDC: begin
        res_o   = add9[7:0];
        cy_o    = add9[8];
        ac_o    = add_lo > 5'd15;
        ov_o    = add9[8] ^ (acc_i[7] ^ opnd_i[7] ^ add9[7]);
        cy_we_o = 1'b1;
        ac_we_o = 1'b1;
        ov_we_o = 1'b1;
      end
      OP_SUBB: begin
        res_o   = sub9[7:0];
        cy_o    = sub9[8];
        ac_o    = sub_lo_brw;
        ov_o    = sub9[8] ^ (acc_i[7] ^ opnd_i[7] ^ sub9[7]);
        cy_we_o = 1'b1;
        ac_we_o = 1'b1;
        ov_we_o = 1'b1;
      end
      OP_INC: res_o = acc_i + 8'd1;
      OP_DEC: res_o = acc_i - 8'd1;
      OP_MUL: begin
        res_o     = prod[7:0];
        res2_o    = prod[15:8];
        res2_we_o = 1'b1;
        cy_o      = 1'b0;
        cy_we_o   = 1'b1;
        ov_o      = prod[15:8] != 8'd0;
        ov_we_o   = 1'b1;
      end
      OP_DIV: begin
        res2_we_o = 1'b1;
        cy_o      = 1'b0;
        cy_we_o   = 1'b1;
        ov_we_o   = 1'b1;
        if (opnd_i == 8'd0) begin
          ov_o = 1'b1;
        end else begin
          res_o  = quot;
          res2_o = rmdr;
        end
      end
      OP_DA: begin
        res_o   = da_res;
        cy_o    = cy_i | da_hi_fix;
        cy_we_o = 1'b1;
      end
      OP_AND:  res_o = acc_i & opnd_i;
      OP_OR:   res_o = acc_i | opnd_i;
      OP_XOR:  res_o = acc_i ^ opnd_i;
      OP_CPL:  res_o = ~acc_i;
      OP_CLR:  res_o = 8'd0;
      OP_RL:   res_o = {acc_i[6:0], acc_i[7]};
      OP_RR:   res_o = {acc_i[0], acc_i[7:1]};
      OP_RLC: begin
        res_o   = {acc_i[6:0], cy_i};
        cy_o    = acc_i[7];
        cy_we_o = 1'b1;
      end
      OP_RRC: begin
        res_o   = {cy_i, acc_i[7:1]};
        cy_o    = acc_i[0];
        cy_we_o = 1'b1;
      end
      OP_SWAP: res_o = {acc_i[3:0], acc_i[7:4]};
      default: ;
    endcase
  end

  always_comb begin
    if (op_i == OP_ADD || op_i == OP_ADDC || op_i == OP_SUBB)
      p_aux_bit4_r2: assert (ac_o == (acc_i[4] ^ opnd_i[4] ^ res_o[4]));
    if (op_i == OP_INC || op_i == OP_DEC)
      p_incdec_noflag_r5: assert (!cy_we_o && !ac_we_o && !ov_we_o);
    if (op_i == OP_MUL)
      p_mul_ov_r6: assert (ov_o == (res2_o != 8'd0) && !cy_o && res2_we_o);
    if (op_i == OP_DIV && opnd_i != 8'd0)
      p_div_recon_r7: assert (({8'd0, res_o} * {8'd0, opnd_i} + {8'd0, res2_o}) == {8'd0, acc_i}
                              && res2_o < opnd_i && !ov_o && !cy_o);
    if (op_i == OP_DIV && opnd_i == 8'd0)
      p_div_zero_r8: assert (ov_o && ov_we_o && res_o == acc_i && res2_o == opnd_i);
    if (op_i == OP_DA)
      p_da_no_clear_r9: assert (!cy_i || cy_o);
    if (op_i >= OP_AND && op_i <= OP_CLR)
      p_logic_noflag_r10: assert (!cy_we_o && !ac_we_o && !ov_we_o && !res2_we_o);
    if (op_i > OP_SWAP)
      p_unused_idle_r12: assert (res_o == acc_i && !res2_we_o && !cy_we_o && !ac_we_o && !ov_we_o);
  end

endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic       clk = 1'b0;
  logic [4:0] op;
  logic [7:0] acc, opnd;
  logic       cy, ac;
  logic [7:0] res, res2;
  logic       res2_we, cy_o, cy_we, ac_o, ac_we, ov_o, ov_we;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  acc_alu dut (
    .op_i(op), .acc_i(acc), .opnd_i(opnd), .cy_i(cy), .ac_i(ac),
    .res_o(res), .res2_o(res2), .res2_we_o(res2_we),
    .cy_o(cy_o), .cy_we_o(cy_we), .ac_o(ac_o), .ac_we_o(ac_we),
    .ov_o(ov_o), .ov_we_o(ov_we)
  );

  task automatic chk(input string rq, input int er, input int e2, input int e2we,
                     input int ecy, input int ecywe, input int eac, input int eacwe,
                     input int eov, input int eovwe);
    bit bad;
    bad = (res != er[7:0]) || (res2_we != e2we[0]) || (e2we[0] && res2 != e2[7:0]) ||
          (cy_we != ecywe[0]) || (ecywe[0] && cy_o != ecy[0]) ||
          (ac_we != eacwe[0]) || (eacwe[0] && ac_o != eac[0]) ||
          (ov_we != eovwe[0]) || (eovwe[0] && ov_o != eov[0]);
    checks++;
    if (bad) begin
      errors++;
      if (errors < 20)
        $display("FAIL %s op=%0d a=%h b=%h c=%b ac=%b: got res=%h r2=%h/%b cy=%b/%b ac=%b/%b ov=%b/%b exp res=%h r2=%h/%0d cy=%0d/%0d ac=%0d/%0d ov=%0d/%0d",
                 rq, op, acc, opnd, cy, ac, res, res2, res2_we, cy_o, cy_we, ac_o, ac_we, ov_o, ov_we,
                 er[7:0], e2[7:0], e2we, ecy, ecywe, eac, eacwe, eov, eovwe);
    end
  endtask

  task automatic drive(input int o, input int a, input int b, input int c, input int x);
    op = o[4:0]; acc = a[7:0]; opnd = b[7:0]; cy = c[0]; ac = x[0];
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    drive(0, 0, 0, 0, 0);
    chk("R1 idle-zero", 0, 0, 0, 0, 1, 0, 1, 0, 1);
    drive(0, 8'h3F, 8'hD3, 0, 0);
    chk("R3 example", 8'h12, 0, 0, 1, 1, 1, 1, 0, 1);
    drive(5, 8'hFF, 8'hFF, 0, 0);
    chk("R6 example", 8'h01, 8'hFE, 1, 0, 1, 0, 0, 1, 1);
    drive(7, 8'h4C, 0, 0, 0);
    chk("R9 example", 8'h52, 0, 0, 0, 1, 0, 0, 0, 0);

    // R1 R2 R3 add / addc, R4 subb
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++) begin
          int s, sa, sb, sd;
          sa = (a > 127) ? a - 256 : a;
          sb = (b > 127) ? b - 256 : b;
          for (int o = 0; o < 2; o++) begin
            int ci;
            ci = (o == 1) ? c : 0;
            drive(o, a, b, c, 0);
            s = a + b + ci;
            chk("R1/R2/R3 add", s % 256, 0, 0, s > 255, 1,
                (a % 16 + b % 16 + ci) > 15, 1,
                (sa + sb + ci > 127) || (sa + sb + ci < -128), 1);
          end
          drive(2, a, b, c, 1);
          sd = sa - sb - c;
          chk("R4 subb", (a - b - c + 512) % 256, 0, 0, a < b + c, 1,
              (a % 16) < (b % 16 + c), 1, (sd > 127) || (sd < -128), 1);
        end

    // R6 mul, R7 div, R8 div by zero, R10 two-operand logic
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        drive(5, a, b, 1, 0);
        chk("R6 mul", (a * b) % 256, (a * b) / 256, 1, 0, 1, 0, 0, (a * b) > 255, 1);
        drive(6, a, b, 1, 0);
        if (b == 0) chk("R8 div0", a, b, 1, 0, 1, 0, 0, 1, 1);
        else        chk("R7 div", a / b, a % b, 1, 0, 1, 0, 0, 0, 1);
        drive(8, a, b, 1, 1);
        chk("R10 and", a & b, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(9, a, b, 0, 1);
        chk("R10 or", a | b, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(10, a, b, 1, 0);
        chk("R10 xor", a ^ b, 0, 0, 0, 0, 0, 0, 0, 0);
      end

    // single-operand operations over every acc and flag pair
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 4; f++) begin
        int c, x, v, c2, hi;
        c = f % 2; x = f / 2;
        drive(3, a, 8'h5A, c, x);
        chk("R5 inc", (a + 1) % 256, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(4, a, 8'h5A, c, x);
        chk("R5 dec", (a + 255) % 256, 0, 0, 0, 0, 0, 0, 0, 0);
        v = a;
        if ((a % 16) > 9 || x == 1) v = v + 6;
        c2 = (c == 1 || v > 255) ? 1 : 0;
        hi = (v / 16) % 16;
        if (hi > 9 || c2 == 1) begin v = v + 8'h60; c2 = 1; end
        drive(7, a, 0, c, x);
        chk("R9 da", v % 256, 0, 0, c2, 1, 0, 0, 0, 0);
        drive(11, a, 0, c, x);
        chk("R10 cpl", 255 - a, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(12, a, 0, c, x);
        chk("R10 clr", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(13, a, 0, c, x);
        chk("R11 rl", (a * 2) % 256 + a / 128, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(14, a, 0, c, x);
        chk("R11 rlc", (a * 2) % 256 + c, 0, 0, a / 128, 1, 0, 0, 0, 0);
        drive(15, a, 0, c, x);
        chk("R11 rr", a / 2 + (a % 2) * 128, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(16, a, 0, c, x);
        chk("R11 rrc", a / 2 + c * 128, 0, 0, a % 2, 1, 0, 0, 0, 0);
        drive(17, a, 0, c, x);
        chk("R11 swap", (a % 16) * 16 + a / 16, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int o = 18; o < 32; o++) begin
          drive(o, a, 8'hC3, c, x);
          chk("R12 unused", a, 0, 0, 0, 0, 0, 0, 0, 0);
        end
      end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule